// File: doc/BRIEF.md
# Performance Level Switch Controller

The block holds the operating performance level of a device: the level that decides which voltage, and so which maximum clock frequency, the core regulator must provide. Software picks a new level by writing a level-select field. The block hands the chosen level to the regulator as a request, holds that request until the regulator acknowledges it, and then commits the level and raises a ready flag. Software keeps the bus frequency low until that flag is seen. When lowering the level, software must first lower the bus frequency. The block does not check the frequency.

Level changes start only while the device is in active mode. A write made outside active mode waits until active mode returns. A write made while a transition is in flight is queued, and the last queued write is used. A disable bit fixes the level at the lowest setting and makes further level writes have no effect. The ready flag is cleared by writing 1 and drives an interrupt line when its enable bit is set.

Top module: `perf_lvl_ctrl`

## Requirements
- R1: After reset `cur_lvl_o` is 0 (lowest level), and `reg_req_o`, `ready_o` and `irq_o` are 0.
- R2: A level write that differs from the current level, made in active mode with nothing in flight, drives `reg_req_o`=1 and `reg_lvl_o`=written level from the second clock edge after the write edge. Both are held unchanged until `reg_ack_i`.
- R3: An acknowledge sampled while a request is open sets `cur_lvl_o` to the requested level, drops `reg_req_o` and sets `ready_o`, all on that same edge.
- R4: A level write equal to the current level issues no request and sets `ready_o` on the second clock edge after the write edge.
- R5: While `active_i`=0 no new request is started. A pending write starts its request on the first edge at which `active_i`=1 is sampled.
- R6: A level write made while a request is open is queued, and a later write replaces it. The queued level is requested on the edge after the acknowledge.
- R7: Writing 1 to the disable bit queues a change to level 0. While the bit is 1, level writes have no effect. Clearing the bit changes no level.
- R8: `flag_clr_i` clears `ready_o` on the next edge. A completion on the same edge wins over the clear, so `ready_o` stays 1.
- R9: `irq_o` is 1 exactly when `ready_o` and the interrupt enable bit are both 1.
- R10: `reg_ack_i` has no effect when no request is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lvl_wr_i | input | 1 | Write strobe for the level-select field |
| lvl_wdata_i | input | LVL_W | Level written |
| dis_wr_i | input | 1 | Write strobe for the disable bit |
| dis_wdata_i | input | 1 | Disable bit value written |
| ien_wr_i | input | 1 | Write strobe for the interrupt enable bit |
| ien_wdata_i | input | 1 | Interrupt enable value written |
| flag_clr_i | input | 1 | Write-1-to-clear strobe for the ready flag |
| active_i | input | 1 | Device is in active mode |
| reg_ack_i | input | 1 | Regulator acknowledge pulse |
| cur_lvl_o | output | LVL_W | Committed performance level |
| reg_req_o | output | 1 | Request open to the regulator |
| reg_lvl_o | output | LVL_W | Level requested from the regulator |
| ready_o | output | 1 | Transition complete flag |
| irq_o | output | 1 | Ready interrupt |

## Verification
A level write is stored on its own edge. It is turned into a request, or into an immediate ready for an equal level, one edge later. An acknowledge commits the level and sets ready on the edge that samples it. A flag clear acts on the next edge, and the interrupt follows the flag and enable bit without delay. The bench drives and samples 1 ns after each rising edge and steps an exact number of edges before each check. For every request it also checks that the request stays high through the acknowledge delay of the regulator model.

// File: rtl/perf_lvl_pkg.sv
package perf_lvl_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_st_e;
endpackage

// File: rtl/perf_lvl_cfg.sv
module perf_lvl_cfg #(
  parameter int unsigned NUM_LEVELS = 4,
  parameter int unsigned LVL_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_wr_i,
  input  logic [LVL_W-1:0] lvl_wdata_i,
  input  logic             dis_wr_i,
  input  logic             dis_wdata_i,
  input  logic             take_i,
  output logic             pend_vld_o,
  output logic [LVL_W-1:0] pend_lvl_o
);
  logic             dis_q;
  logic             pend_vld_q;
  logic [LVL_W-1:0] pend_lvl_q;
  logic             code_ok;
  logic             dis_rise;
  logic             lvl_accept;

  // codes beyond the implemented levels are dropped
  generate
    if ((1 << LVL_W) == NUM_LEVELS) begin : g_full
      assign code_ok = 1'b1;
    end else begin : g_part
      assign code_ok = (32'(lvl_wdata_i) < NUM_LEVELS);
    end
  endgenerate

  assign dis_rise   = dis_wr_i && dis_wdata_i && !dis_q;
  assign lvl_accept = lvl_wr_i && !dis_q && code_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= 1'b0;
    end else if (dis_wr_i) begin
      dis_q <= dis_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_lvl_q <= '0;
    end else if (dis_rise) begin
      pend_vld_q <= 1'b1;
      pend_lvl_q <= '0;
    end else if (lvl_accept) begin
      pend_vld_q <= 1'b1;
      pend_lvl_q <= lvl_wdata_i;
    end else if (take_i) begin
      pend_vld_q <= 1'b0;
    end
  end

  assign pend_vld_o = pend_vld_q;
  assign pend_lvl_o = pend_lvl_q;

  // R7
  dis_pins_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q |-> (!pend_vld_q || pend_lvl_q == '0));

  // R7
  dis_ignores_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_q && !dis_wr_i && !take_i) |=> $stable(pend_lvl_q) && $stable(pend_vld_q));
endmodule

// File: rtl/perf_lvl_seq.sv
module perf_lvl_seq
  import perf_lvl_pkg::*;
#(
  parameter int unsigned LVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             pend_vld_i,
  input  logic [LVL_W-1:0] pend_lvl_i,
  input  logic             ack_i,
  output logic             take_o,
  output logic             done_o,
  output logic             req_o,
  output logic [LVL_W-1:0] req_lvl_o,
  output logic [LVL_W-1:0] cur_lvl_o
);
  seq_st_e          state_q, state_d;
  logic [LVL_W-1:0] cur_q, req_q;
  logic             same_lvl, ack_hit;

  assign take_o   = (state_q == SEQ_IDLE) && pend_vld_i && active_i;
  assign same_lvl = (pend_lvl_i == cur_q);
  assign ack_hit  = (state_q == SEQ_BUSY) && ack_i;
  assign done_o   = (take_o && same_lvl) || ack_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (take_o && !same_lvl) state_d = SEQ_BUSY;
      SEQ_BUSY: if (ack_i) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      req_q   <= '0;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take_o && !same_lvl) req_q <= pend_lvl_i;
      if (ack_hit) cur_q <= req_q;
    end
  end

  assign req_o     = (state_q == SEQ_BUSY);
  assign req_lvl_o = req_q;
  assign cur_lvl_o = cur_q;

  // R2
  req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o && $stable(req_lvl_o));

  // R3 R10
  lvl_only_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_hit |=> $stable(cur_lvl_o));

  // R4
  same_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && same_lvl) |=> !req_o);

  // R5
  idle_when_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !req_o) |=> !req_o);
endmodule

// File: rtl/perf_lvl_flag.sv
module perf_lvl_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_wr_i,
  input  logic ien_wdata_i,
  output logic ready_o,
  output logic irq_o
);
  logic ready_q, ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      ien_q   <= 1'b0;
    end else begin
      if (set_i)      ready_q <= 1'b1;
      else if (clr_i) ready_q <= 1'b0;
      if (ien_wr_i)   ien_q   <= ien_wdata_i;
    end
  end

  assign ready_o = ready_q;
  assign irq_o   = ready_q && ien_q;

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ready_o);

  // R8
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !ready_o);
endmodule

// File: rtl/perf_lvl_ctrl.sv
module perf_lvl_ctrl #(
  parameter int unsigned NUM_LEVELS = 4,
  localparam int unsigned LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_wr_i,
  input  logic [LVL_W-1:0] lvl_wdata_i,
  input  logic             dis_wr_i,
  input  logic             dis_wdata_i,
  input  logic             ien_wr_i,
  input  logic             ien_wdata_i,
  input  logic             flag_clr_i,
  input  logic             active_i,
  input  logic             reg_ack_i,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic             reg_req_o,
  output logic [LVL_W-1:0] reg_lvl_o,
  output logic             ready_o,
  output logic             irq_o
);
  logic             pend_vld, take, done;
  logic [LVL_W-1:0] pend_lvl;

  perf_lvl_cfg #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_wr_i    (lvl_wr_i),
    .lvl_wdata_i (lvl_wdata_i),
    .dis_wr_i    (dis_wr_i),
    .dis_wdata_i (dis_wdata_i),
    .take_i      (take),
    .pend_vld_o  (pend_vld),
    .pend_lvl_o  (pend_lvl)
  );

  perf_lvl_seq #(.LVL_W(LVL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active_i),
    .pend_vld_i (pend_vld),
    .pend_lvl_i (pend_lvl),
    .ack_i      (reg_ack_i),
    .take_o     (take),
    .done_o     (done),
    .req_o      (reg_req_o),
    .req_lvl_o  (reg_lvl_o),
    .cur_lvl_o  (cur_lvl_o)
  );

  perf_lvl_flag u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (done),
    .clr_i       (flag_clr_i),
    .ien_wr_i    (ien_wr_i),
    .ien_wdata_i (ien_wdata_i),
    .ready_o     (ready_o),
    .irq_o       (irq_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (cur_lvl_o == '0 && !reg_req_o && !ready_o));
endmodule

// File: tb/perf_lvl_ctrl_tb.sv
module perf_lvl_ctrl_tb;
  localparam int ACK_DLY = 3;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lvl_wr = 1'b0, dis_wr = 1'b0, dis_wd = 1'b0;
  logic ien_wr = 1'b0, ien_wd = 1'b0, flag_clr = 1'b0;
  logic active = 1'b1, ack = 1'b0;
  logic [LW-1:0] lvl_wd = '0;
  logic [LW-1:0] cur_lvl, reg_lvl;
  logic reg_req, ready, irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  perf_lvl_ctrl #(.NUM_LEVELS(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lvl_wr_i(lvl_wr), .lvl_wdata_i(lvl_wd),
    .dis_wr_i(dis_wr), .dis_wdata_i(dis_wd),
    .ien_wr_i(ien_wr), .ien_wdata_i(ien_wd),
    .flag_clr_i(flag_clr), .active_i(active), .reg_ack_i(ack),
    .cur_lvl_o(cur_lvl), .reg_req_o(reg_req), .reg_lvl_o(reg_lvl),
    .ready_o(ready), .irq_o(irq)
  );

  // {level written, request expected}
  localparam logic [2:0] VEC [8] = '{
    {2'd2, 1'b1}, {2'd2, 1'b0}, {2'd3, 1'b1}, {2'd1, 1'b1},
    {2'd1, 1'b0}, {2'd0, 1'b1}, {2'd3, 1'b1}, {2'd0, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_lvl(input logic [LW-1:0] v);
    lvl_wr = 1'b1; lvl_wd = v;
    step();
    lvl_wr = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
  endtask

  // regulator model: ack pulse ACK_DLY cycles after request opened
  task automatic reg_ack(input string tag, input int lvl);
    for (int i = 1; i < ACK_DLY; i++) begin
      step();
      check({tag, " req held"}, int'(reg_req), 1);
    end
    ack = 1'b1;
    step();
    ack = 1'b0;
    check({tag, " level"}, int'(cur_lvl), lvl);
    check({tag, " ready"}, int'(ready), 1);
    check({tag, " req drop"}, int'(reg_req), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int cur;
    // R1
    #5;
    check("R1 level", int'(cur_lvl), 0);
    check("R1 req", int'(reg_req), 0);
    check("R1 ready", int'(ready), 0);
    check("R1 irq", int'(irq), 0);
    step(2);
    rst_ni = 1'b1;
    step(2);
    check("R1 level run", int'(cur_lvl), 0);

    // R2 R3 R4 vector walk
    cur = 0;
    foreach (VEC[k]) begin
      wr_lvl(VEC[k][2:1]);
      check("R2 no req at write", int'(reg_req), 0);
      step();
      if (VEC[k][0]) begin
        check("R2 req", int'(reg_req), 1);
        check("R2 req lvl", int'(reg_lvl), int'(VEC[k][2:1]));
        reg_ack("R3", int'(VEC[k][2:1]));
        cur = int'(VEC[k][2:1]);
      end else begin
        check("R4 no req", int'(reg_req), 0);
        check("R4 ready", int'(ready), 1);
        check("R4 level", int'(cur_lvl), cur);
      end
      clr_flag();
      check("R8 clear", int'(ready), 0);
    end

    // R9
    ien_wr = 1'b1; ien_wd = 1'b1; step(); ien_wr = 1'b0;
    check("R9 irq no flag", int'(irq), 0);
    wr_lvl(2'd0); step();
    check("R9 irq on", int'(irq), 1);
    ien_wr = 1'b1; ien_wd = 1'b0; step(); ien_wr = 1'b0;
    check("R9 irq masked", int'(irq), 0);
    clr_flag();

    // R5
    active = 1'b0;
    wr_lvl(2'd2);
    step(3);
    check("R5 held", int'(reg_req), 0);
    active = 1'b1;
    step();
    check("R5 start", int'(reg_req), 1);
    check("R5 lvl", int'(reg_lvl), 2);
    // R8 set and clear on the same edge: set wins
    step(ACK_DLY - 1);
    ack = 1'b1; flag_clr = 1'b1;
    step();
    ack = 1'b0; flag_clr = 1'b0;
    check("R8 set wins", int'(ready), 1);
    check("R5 level", int'(cur_lvl), 2);
    clr_flag();

    // R6 queued writes, last wins
    wr_lvl(2'd3); step();
    check("R6 first req", int'(reg_lvl), 3);
    wr_lvl(2'd1);
    wr_lvl(2'd0);
    check("R6 req lvl kept", int'(reg_lvl), 3);
    ack = 1'b1; step(); ack = 1'b0;
    check("R6 level", int'(cur_lvl), 3);
    step();
    check("R6 queued req", int'(reg_req), 1);
    check("R6 queued lvl", int'(reg_lvl), 0);
    reg_ack("R6", 0);
    clr_flag();

    // R10
    ack = 1'b1; step(); ack = 1'b0;
    check("R10 level", int'(cur_lvl), 0);
    check("R10 ready", int'(ready), 0);

    // R7
    wr_lvl(2'd2); step(); reg_ack("R7 pre", 2); clr_flag();
    dis_wr = 1'b1; dis_wd = 1'b1; step(); dis_wr = 1'b0;
    step();
    check("R7 forced req", int'(reg_req), 1);
    check("R7 forced lvl", int'(reg_lvl), 0);
    wr_lvl(2'd3);
    reg_ack("R7", 0);
    step(3);
    check("R7 write ignored", int'(reg_req), 0);
    check("R7 level stays", int'(cur_lvl), 0);
    clr_flag();
    dis_wr = 1'b1; dis_wd = 1'b0; step(); dis_wr = 1'b0;
    step(2);
    check("R7 clear no change", int'(reg_req), 0);
    check("R7 clear no ready", int'(ready), 0);
    wr_lvl(2'd1); step();
    check("R7 re-enabled", int'(reg_lvl), 1);
    reg_ack("R7 post", 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule